// File: doc/BRIEF.md
# Serial ADC Read Master

This block is the host-side controller for an 8-bit serial converter that needs no command word. A conversion is started by a low-going edge on a convert-start line. The converter then runs on its own internal clock. After that, the host clocks the result out over a clock line and a single data line. The block accepts a request carrying a one-bit channel choice and drives the convert-start pulse. When the mid-supply self-test channel is chosen, it follows with a second high-then-low toggle. It then keeps the serial clock idle for the whole conversion wait. Finally it produces eight clock pulses and shifts in the result, most significant bit first.

Every duration is a parameterised count of system clocks: the start pulse, the gap before a second toggle, the conversion wait, and the clock high and low phases. At elaboration these counts are checked against the clock period parameter and the converter's minimum times. The idle clock level is a parameter, so the block serves both shared-edge SPI modes: mode 0 (idle low) and mode 3 (idle high). The converter changes its data on falling clock edges, so the block always samples on rising edges.

Requests use a valid/ready handshake, and a request is taken only while the block is idle. The result byte leaves on a valid/ready stream. A result that is not taken keeps the block in its holding state, with the byte frozen. The block accepts no new request until the byte has been consumed. This ensures a new conversion never starts before the previous result is fully read. Requests made while busy are refused, not queued.

Top module: `sadc_reader`

## Requirements
- R1: After reset `conv_start` is 0, `ser_clk` equals CPOL, `req_ready` is 1 and `res_valid` is 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. From the next cycle `conv_start` is 1 for exactly START_HI_CYC cycles, then returns to 0, and `req_ready` stays 0 until the result has been taken.
- R3: With `req_mid`=0 at acceptance the conversion shows one falling edge of `conv_start`. With `req_mid`=1 it shows two: after the first fall, the line is low for START_HI_CYC cycles, high for START_HI_CYC cycles, then low again.
- R4: `ser_clk` does not change for CONV_WAIT_CYC cycles after the last falling edge of `conv_start`.
- R5: Each conversion gives exactly 8 rising edges of `ser_clk`. Every driven high phase lasts SCLK_HI_CYC cycles and every driven low phase lasts SCLK_LO_CYC cycles.
- R6: `ser_din` is sampled at each rising edge of `ser_clk`. The first sample becomes bit 7 of `res_data` and the eighth becomes bit 0.
- R7: CPOL=0 starts the read with a rising edge and leaves `ser_clk` at 0. CPOL=1 starts it with a falling edge and leaves `ser_clk` at 1.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1, `res_data` stays unchanged and `req_ready` stays 0.
- R9: A request seen while `req_ready` is 0, including in the cycle the result is taken, is dropped. It starts no conversion later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Block idle, request would be taken |
| req_mid | input | 1 | 1 selects the mid-supply self-test channel |
| conv_start | output | 1 | Convert-start line to the converter |
| ser_clk | output | 1 | Serial clock to the converter |
| ser_din | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result byte available |
| res_ready | input | 1 | Consumer takes the result byte |
| res_data | output | 8 | Captured result, MSB first on the wire |

## Verification
A request can arrive in the same cycle the held result is accepted. At that edge the completion handshake and the request refusal coincide. The bench drives `res_ready` and `req_valid` together for exactly that one cycle. It then checks on the following cycles that the block is idle, that `conv_start` stays low and that the converter model counts no extra start edge. Two instances, one per clock polarity, are swept over a set of result bytes, both channels and several back-pressure lengths. Each returned byte is compared with the value the converter model presented.

// File: rtl/sadc_reader_pkg.sv
`timescale 1ns/1ps
package sadc_reader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_GAP,
    ST_CONV,
    ST_SHIFT,
    ST_HOLD
  } rd_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sadc_phase_timer.sv
`timescale 1ns/1ps
module sadc_phase_timer #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sadc_capture_shift.sv
`timescale 1ns/1ps
module sadc_capture_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift_en,
  input  logic          din,
  output logic [DW-1:0] data,
  output logic          full
);

  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (shift_en) begin
      data_q <= {data_q[DW-2:0], din};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign data = data_q;
  assign full = (cnt_q == CW'(DW));

endmodule

// File: rtl/sadc_reader.sv
`timescale 1ns/1ps
module sadc_reader
  import sadc_reader_pkg::*;
#(
  parameter int CPOL          = 0,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int START_HI_CYC  = 10,
  parameter int CONV_WAIT_CYC = 1500,
  parameter int SCLK_HI_CYC   = 20,
  parameter int SCLK_LO_CYC   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mid,
  output logic              conv_start,
  output logic              ser_clk,
  input  logic              ser_din,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data
);

  localparam int   MAXC     = max2(max2(START_HI_CYC, CONV_WAIT_CYC),
                                   max2(SCLK_HI_CYC, SCLK_LO_CYC));
  localparam int   TW       = $clog2(MAXC + 1);
  localparam logic IDLE_LVL = (CPOL != 0);

  // Timing floors of the converter, in picoseconds.
  localparam longint START_PS  = longint'(START_HI_CYC) * CLK_PERIOD_PS;
  localparam longint CONV_PS   = longint'(CONV_WAIT_CYC) * CLK_PERIOD_PS;
  localparam longint HI_PS     = longint'(SCLK_HI_CYC) * CLK_PERIOD_PS;
  localparam longint LO_PS     = longint'(SCLK_LO_CYC) * CLK_PERIOD_PS;

  if (START_PS < 50000) begin : g_bad_start
    $error("start pulse shorter than 50 ns");
  end
  if (CONV_PS < 7500000) begin : g_bad_conv
    $error("conversion wait shorter than 7.5 us");
  end
  if (HI_PS < 75000 || LO_PS < 75000) begin : g_bad_phase
    $error("serial clock phase shorter than 75 ns");
  end
  if (HI_PS + LO_PS < 200000) begin : g_bad_rate
    $error("serial clock faster than 5 MHz");
  end
  if (DATA_W < 2) begin : g_bad_width
    $error("result width below 2");
  end

  rd_state_t st_q, st_n;
  logic cs_q, cs_n, sclk_q, sclk_n, sec_q, sec_n, mid_q, mid_n;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          sh_clr, sh_en, sh_full;

  sadc_phase_timer #(.W(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  sadc_capture_shift #(.DW(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .clear(sh_clr), .shift_en(sh_en),
    .din(ser_din), .data(res_data), .full(sh_full)
  );

  always_comb begin
    st_n   = st_q;
    cs_n   = cs_q;
    sclk_n = sclk_q;
    sec_n  = sec_q;
    mid_n  = mid_q;
    t_load = 1'b0;
    t_val  = '0;
    sh_clr = 1'b0;
    sh_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        st_n   = ST_PULSE;
        cs_n   = 1'b1;
        sec_n  = 1'b0;
        mid_n  = req_mid;
        t_load = 1'b1;
        t_val  = TW'(START_HI_CYC - 1);
        sh_clr = 1'b1;
      end
      ST_PULSE: if (t_zero) begin
        cs_n   = 1'b0;
        t_load = 1'b1;
        if (mid_q && !sec_q) begin
          st_n  = ST_GAP;
          t_val = TW'(START_HI_CYC - 1);
        end else begin
          st_n  = ST_CONV;
          t_val = TW'(CONV_WAIT_CYC - 1);
        end
      end
      ST_GAP: if (t_zero) begin
        st_n   = ST_PULSE;
        cs_n   = 1'b1;
        sec_n  = 1'b1;
        t_load = 1'b1;
        t_val  = TW'(START_HI_CYC - 1);
      end
      ST_CONV: if (t_zero) begin
        st_n   = ST_SHIFT;
        t_load = 1'b1;
        if (IDLE_LVL) begin
          sclk_n = 1'b0;
          t_val  = TW'(SCLK_LO_CYC - 1);
        end else begin
          sclk_n = 1'b1;
          sh_en  = 1'b1;
          t_val  = TW'(SCLK_HI_CYC - 1);
        end
      end
      ST_SHIFT: if (t_zero) begin
        if (sclk_q) begin
          if (sh_full) begin
            st_n   = ST_HOLD;
            sclk_n = IDLE_LVL;
          end else begin
            sclk_n = 1'b0;
            t_load = 1'b1;
            t_val  = TW'(SCLK_LO_CYC - 1);
          end
        end else begin
          sclk_n = 1'b1;
          sh_en  = 1'b1;
          t_load = 1'b1;
          t_val  = TW'(SCLK_HI_CYC - 1);
        end
      end
      ST_HOLD: if (res_ready) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cs_q   <= 1'b0;
      sclk_q <= IDLE_LVL;
      sec_q  <= 1'b0;
      mid_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cs_q   <= cs_n;
      sclk_q <= sclk_n;
      sec_q  <= sec_n;
      mid_q  <= mid_n;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign res_valid  = (st_q == ST_HOLD);
  assign conv_start = cs_q;
  assign ser_clk    = sclk_q;

endmodule

// File: rtl/sadc_reader_chk.sv
`timescale 1ns/1ps
module sadc_reader_chk #(
  parameter int CPOL          = 0,
  parameter int DATA_W        = 8,
  parameter int START_HI_CYC  = 10,
  parameter int CONV_WAIT_CYC = 1500,
  parameter int SCLK_HI_CYC   = 20,
  parameter int SCLK_LO_CYC   = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              conv_start,
  input logic              ser_clk,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data
);

  logic [31:0] cs_hi_run, clk_hi_run, clk_lo_run, since_fall, rise_cnt;
  logic        cs_d, sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hi_run  <= '0;
      clk_hi_run <= '0;
      clk_lo_run <= '0;
      since_fall <= '1;
      rise_cnt   <= '0;
      cs_d       <= 1'b0;
      sclk_d     <= (CPOL != 0);
    end else begin
      cs_d       <= conv_start;
      sclk_d     <= ser_clk;
      cs_hi_run  <= conv_start ? cs_hi_run + 1 : '0;
      clk_hi_run <= ser_clk ? clk_hi_run + 1 : '0;
      clk_lo_run <= ser_clk ? '0 : clk_lo_run + 1;
      if (cs_d && !conv_start)   since_fall <= 32'd1;
      else if (since_fall != '1) since_fall <= since_fall + 1;
      if (req_valid && req_ready)  rise_cnt <= '0;
      else if (ser_clk && !sclk_d) rise_cnt <= rise_cnt + 1;
    end
  end

  // R2
  start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_start) |-> cs_hi_run >= START_HI_CYC);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> conv_start && !req_ready);

  // R4
  conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_clk) |-> since_fall >= CONV_WAIT_CYC);

  // R5
  clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> clk_hi_run >= SCLK_HI_CYC);

  // R5
  clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> clk_lo_run >= SCLK_LO_CYC);

  // R5
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> rise_cnt == DATA_W);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && !req_ready);

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !conv_start && (ser_clk == (CPOL != 0)));

endmodule

bind sadc_reader sadc_reader_chk #(
  .CPOL(CPOL), .DATA_W(DATA_W), .START_HI_CYC(START_HI_CYC),
  .CONV_WAIT_CYC(CONV_WAIT_CYC), .SCLK_HI_CYC(SCLK_HI_CYC), .SCLK_LO_CYC(SCLK_LO_CYC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .conv_start(conv_start), .ser_clk(ser_clk), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data)
);

// File: tb/test_sadc_reader.sv
`timescale 1ns/1ps
module sadc_conv_model (
  input  logic       cs,
  input  logic       sclk,
  input  logic [7:0] ext_val,
  input  logic [7:0] mid_val,
  output logic       miso,
  output int         falls,
  output int         rises,
  output int         early
);
  real  t_fall;
  bit   pending, mid_sel;
  int   gen;
  logic [7:0] tmp;

  initial begin
    miso = 1'b0; falls = 0; rises = 0; early = 0;
    t_fall = -1.0e9; pending = 0; mid_sel = 0; gen = 0;
  end

  always @(negedge cs) begin
    falls++;
    if (pending) mid_sel = 1;
    else begin pending = 1; mid_sel = 0; end
    rises  = 0;
    t_fall = $realtime;
    gen++;
    miso = 1'b0;
    fork
      begin
        automatic int g = gen;
        #7500;
        if (g == gen) begin
          tmp  = mid_sel ? mid_val : ext_val;
          miso = tmp[7];
        end
      end
    join_none
  end

  always @(posedge sclk) begin
    if ($realtime - t_fall < 7500.0) early++;
    rises++;
    if (rises == 8) pending = 0;
  end

  always @(negedge sclk) begin
    if ($realtime - t_fall < 7500.0) early++;
    if (rises < 8) begin
      tmp  = mid_sel ? mid_val : ext_val;
      miso = tmp[7 - rises];
    end
  end
endmodule

module test_sadc_reader;
  localparam int SH = 10, CW = 1500, HI = 20, LO = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_mid = 1'b0, res_ready = 1'b0;
  logic [7:0] ext_val = 8'h00, mid_val = 8'h00;
  logic rdy0, cs0, sclk0, miso0, rv0, rdy1, cs1, sclk1, miso1, rv1;
  logic [7:0] rd0, rd1;
  int falls0, rises0, early0, falls1, rises1, early1;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sadc_reader #(.CPOL(0), .START_HI_CYC(SH), .CONV_WAIT_CYC(CW),
                .SCLK_HI_CYC(HI), .SCLK_LO_CYC(LO)) i_sadc_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0), .req_mid(req_mid),
    .conv_start(cs0), .ser_clk(sclk0), .ser_din(miso0), .res_valid(rv0),
    .res_ready(res_ready), .res_data(rd0));

  sadc_reader #(.CPOL(1), .START_HI_CYC(SH), .CONV_WAIT_CYC(CW),
                .SCLK_HI_CYC(HI), .SCLK_LO_CYC(LO)) i_sadc_reader_m3 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1), .req_mid(req_mid),
    .conv_start(cs1), .ser_clk(sclk1), .ser_din(miso1), .res_valid(rv1),
    .res_ready(res_ready), .res_data(rd1));

  sadc_conv_model i_model0 (.cs(cs0), .sclk(sclk0), .ext_val(ext_val), .mid_val(mid_val),
    .miso(miso0), .falls(falls0), .rises(rises0), .early(early0));
  sadc_conv_model i_model1 (.cs(cs1), .sclk(sclk1), .ext_val(ext_val), .mid_val(mid_val),
    .miso(miso1), .falls(falls1), .rises(rises1), .early(early1));

  // Pulse-width monitors, sampled away from the active edge.
  int run_cs[2], run_hi[2], run_lo[2], min_cs[2], min_hi[2], min_lo[2];
  logic pcs[2], psc[2];
  initial for (int k = 0; k < 2; k++) begin
    run_cs[k] = 0; run_hi[k] = 0; run_lo[k] = 0;
    min_cs[k] = 1 << 30; min_hi[k] = 1 << 30; min_lo[k] = 1 << 30;
    pcs[k] = 1'b0; psc[k] = (k == 1);
  end

  task automatic mon(input int k, input logic c, input logic s);
    if (c) run_cs[k]++;
    else if (pcs[k]) begin
      if (run_cs[k] < min_cs[k]) min_cs[k] = run_cs[k];
      run_cs[k] = 0;
    end
    if (s != psc[k]) begin
      if (psc[k]) begin if (run_hi[k] < min_hi[k]) min_hi[k] = run_hi[k]; end
      else        begin if (run_lo[k] < min_lo[k]) min_lo[k] = run_lo[k]; end
      run_hi[k] = 0; run_lo[k] = 0;
    end
    if (s) run_hi[k]++; else run_lo[k]++;
    pcs[k] = c; psc[k] = s;
  endtask

  always @(negedge clk) if (rst_n) begin
    mon(0, cs0, sclk0);
    mon(1, cs1, sclk1);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_one(input bit m, input logic [7:0] e, input logic [7:0] mv, input int hold);
    int f0, f1, n, nf;
    logic [7:0] exp;
    ext_val = e; mid_val = mv;
    f0 = falls0; f1 = falls1;
    exp = m ? mv : e;
    nf  = m ? 2 : 1;
    @(negedge clk);
    req_valid = 1'b1; req_mid = m;
    @(negedge clk);
    req_valid = 1'b0; req_mid = 1'b0;
    chk(cs0 && !rdy0, "R2 mode0 start/ready", {cs0, rdy0}, 2);
    chk(cs1 && !rdy1, "R2 mode3 start/ready", {cs1, rdy1}, 2);
    repeat (60) @(negedge clk);
    req_valid = 1'b1;                      // R9: request while busy
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!(rv0 && rv1) && n < 5000) begin @(negedge clk); n++; end
    chk(rv0 && rv1, "R6 result valid", {rv0, rv1}, 3);
    chk(rd0 == exp, "R6 mode0 data", rd0, exp);
    chk(rd1 == exp, "R6 mode3 data", rd1, exp);
    chk(sclk0 == 1'b0, "R7 mode0 rest level", sclk0, 0);
    chk(sclk1 == 1'b1, "R7 mode3 rest level", sclk1, 1);
    chk(rises0 == 8 && rises1 == 8, "R5 rising edges", rises0 * 100 + rises1, 808);
    chk(falls0 - f0 == nf, "R3 mode0 start edges", falls0 - f0, nf);
    chk(falls1 - f1 == nf, "R3 mode3 start edges", falls1 - f1, nf);
    chk(early0 == 0 && early1 == 0, "R4 clock during conversion", early0 + early1, 0);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(rv0 && rv1 && !rdy0 && !rdy1, "R8 held valid", {rv0, rv1, rdy0, rdy1}, 12);
      chk(rd0 == exp && rd1 == exp, "R8 held data", rd0, exp);
    end
    res_ready = 1'b1; req_valid = 1'b1;    // R9: request in the taking cycle
    @(negedge clk);
    res_ready = 1'b0; req_valid = 1'b0;
    chk(!rv0 && !rv1 && rdy0 && rdy1, "R9 idle after take", {rv0, rv1, rdy0, rdy1}, 3);
    repeat (3) @(negedge clk);
    chk(!cs0 && !cs1 && falls0 - f0 == nf && falls1 - f1 == nf,
        "R9 no queued start", falls0 - f0, nf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cs0 && sclk0 == 1'b0 && rdy0 && !rv0, "R1 mode0 reset", {cs0, sclk0, rdy0, rv0}, 2);
    chk(!cs1 && sclk1 == 1'b1 && rdy1 && !rv1, "R1 mode3 reset", {cs1, sclk1, rdy1, rv1}, 6);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] e;
      e = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'h80 : (i == 3) ? 8'h01
                                      : 8'((i * 73 + 11) % 256);
      run_one(i[0], e, e ^ 8'hA5, (i % 3) * 4);
    end
    chk(min_cs[0] == SH && min_cs[1] == SH, "R2 start pulse width", min_cs[0], SH);
    chk(min_hi[0] == HI && min_hi[1] == HI, "R5 clock high width", min_hi[0] * 1000 + min_hi[1], HI * 1001);
    chk(min_lo[0] == LO && min_lo[1] == LO, "R5 clock low width", min_lo[0] * 1000 + min_lo[1], LO * 1001);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule